// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block generates the system reset from three sources: a comparator flag that reports the supply is above its threshold, a shared open-drain reset pin that other agents can pull, and a watchdog that expects periodic activity. Every input is synchronised to the system clock. The supply flag is also filtered, so short spikes are rejected. Once every cause has cleared, reset stays asserted for a programmable stretch interval and is then released.

The stretch interval and the watchdog window are counted in ticks of a prescaler, so real-time values (about 200 ms stretch, 1.6 s window) come from parameters. A bench can shrink the same parameters to a few clocks. A parameter selects the watchdog activity source: toggles on a dedicated kick input, edges on chip-select, or no watchdog at all. The reset is given in both polarities. A drive-enable output tells the pad when to pull the pin; while it is low the pin is left to its pull resistor.

Top module: `supv_reset_ctrl`

## Requirements
- R1: Reset is asserted while the filtered supply flag is low. After `supplyOk` falls, reset asserts exactly GLITCH_CYCLES+3 clocks later: two synchroniser stages, GLITCH_CYCLES filter clocks and one state register.
- R2: With TICK_DIV=1, after `supplyOk` rises and stays high, reset releases exactly GLITCH_CYCLES+STRETCH_TICKS+3 clocks later.
- R3: A level on `supplyOk` that lasts fewer than GLITCH_CYCLES clocks is ignored in either direction. A level that lasts exactly GLITCH_CYCLES clocks is accepted.
- R4: While reset is released, a low level on `extRstN` (the sensed pin, active-low) asserts reset 3 clocks later and starts a full stretch. While the block itself drives reset, `extRstN` is ignored, so holding it low does not extend the stretch.
- R5: In the run state the watchdog expires when no activity has been seen for WDOG_TICKS ticks. With no activity at all, reset asserts exactly WDOG_TICKS clocks after release (TICK_DIV=1). A gap of at most WDOG_TICKS clocks between activity events never expires.
- R6: The watchdog counter is held at zero while reset is asserted, so every release starts a full watchdog window.
- R7: `rstOut` is active high, `rstOutN` is its complement, and `rstDriveEn` is high exactly while reset is asserted. In the arstN-reset state the outputs are rstOut=1, rstOutN=0, rstDriveEn=1.
- R8: WDOG_SRC selects the activity source: 0 = watchdog off, 1 = any toggle on `wdKick`, 2 = any edge on `chipSel`. Activity on the source that is not selected has no effect.
- R9: A watchdog expiry causes the same reset stretch of STRETCH_TICKS ticks, STRETCH_TICKS clocks at TICK_DIV=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arstN | input | 1 | Asynchronous clear of the block's own flops, active low |
| supplyOk | input | 1 | Comparator flag, high when the supply is above threshold |
| extRstN | input | 1 | Sensed level of the shared reset pin, low = external reset |
| wdKick | input | 1 | Dedicated watchdog activity input, any toggle counts |
| chipSel | input | 1 | Chip-select, any edge counts as activity when selected |
| rstOut | output | 1 | System reset, active high |
| rstOutN | output | 1 | System reset, active low |
| rstDriveEn | output | 1 | Pad drive enable for the open-drain reset pin |

## Verification
The bench builds three copies, one per WDOG_SRC value, with TICK_DIV=1, GLITCH_CYCLES=4, STRETCH_TICKS=40 and WDOG_TICKS=60. With these values every latency is a small exact clock count, so release and expiry times can be compared cycle for cycle. Glitch pulses of three and four clocks sit on either side of the filter boundary. Randomly spaced kicks of up to the full window exercise the edge of watchdog expiry, and the off and chip-select copies show that activity on a source that is not selected is ignored.

// File: rtl/supv_pkg.sv
package supv_pkg;

  localparam int WDSRC_OFF  = 0;
  localparam int WDSRC_KICK = 1;
  localparam int WDSRC_CS   = 2;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_RUN     = 2'd2
  } supvState_e;

  typedef struct packed {
    logic runStretch;
    logic runWdog;
  } ctrlStrobes_t;

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int GLITCH_CYCLES = 2,
  parameter int TICK_DIV      = 10000,
  parameter int STRETCH_TICKS = 200,
  parameter int WDOG_TICKS    = 1600,
  parameter int WDOG_SRC      = WDSRC_KICK,
  parameter int WCW           = $clog2(WDOG_TICKS + 1)
) (
  input  logic           clk,
  input  logic           arstN,
  input  logic           supplyOk,
  input  logic           extRstN,
  input  logic           wdKick,
  input  logic           chipSel,
  input  ctrlStrobes_t   stb,
  output logic           supplyGood,
  output logic           extActive,
  output logic           stretchDone,
  output logic           wdogExpired,
  output logic [WCW-1:0] wdCnt
);

  localparam int GCW = $clog2(GLITCH_CYCLES + 1);
  localparam int SCW = $clog2(STRETCH_TICKS + 1);

  logic [1:0]     supSh;
  logic [1:0]     extSh;
  logic [GCW-1:0] glCnt;
  logic [SCW-1:0] stCnt;
  logic           tick;
  logic           activity;

  // input synchronisers
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      supSh <= 2'b00;
      extSh <= 2'b11;
    end else begin
      supSh <= {supSh[0], supplyOk};
      extSh <= {extSh[0], extRstN};
    end
  end
  assign extActive = ~extSh[1];

  // glitch filter: new level accepted after GLITCH_CYCLES agreeing samples
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      supplyGood <= 1'b0;
      glCnt      <= '0;
    end else if (supSh[1] == supplyGood) begin
      glCnt <= '0;
    end else if (glCnt == GCW'(GLITCH_CYCLES - 1)) begin
      supplyGood <= supSh[1];
      glCnt      <= '0;
    end else begin
      glCnt <= glCnt + 1'b1;
    end
  end

  // prescaler
  generate
    if (TICK_DIV == 1) begin : g_noDiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PCW = $clog2(TICK_DIV + 1);
      logic [PCW-1:0] preCnt;
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN)                              preCnt <= '0;
        else if (preCnt == PCW'(TICK_DIV - 1))   preCnt <= '0;
        else                                     preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PCW'(TICK_DIV - 1));
    end
  endgenerate

  // reset stretch counter
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                                   stCnt <= '0;
    else if (!stb.runStretch)                     stCnt <= '0;
    else if (tick && stCnt != SCW'(STRETCH_TICKS - 1)) stCnt <= stCnt + 1'b1;
  end
  assign stretchDone = stb.runStretch && tick && (stCnt == SCW'(STRETCH_TICKS - 1));

  // watchdog source selection and counter
  logic unusedSrc;
  assign unusedSrc = wdKick ^ chipSel;

  generate
    if (WDOG_SRC == WDSRC_OFF) begin : g_wdOff
      assign activity    = 1'b0;
      assign wdCnt       = '0;
      assign wdogExpired = 1'b0;
    end else begin : g_wdOn
      logic [2:0]     srcSh;
      logic [WCW-1:0] wdReg;
      logic           srcBit;
      assign srcBit = (WDOG_SRC == WDSRC_CS) ? chipSel : wdKick;
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) srcSh <= 3'b000;
        else        srcSh <= {srcSh[1:0], srcBit};
      end
      assign activity = srcSh[2] ^ srcSh[1];
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN)                                     wdReg <= '0;
        else if (!stb.runWdog || activity)              wdReg <= '0;
        else if (tick && wdReg != WCW'(WDOG_TICKS - 1)) wdReg <= wdReg + 1'b1;
      end
      assign wdCnt       = wdReg;
      assign wdogExpired = stb.runWdog && !activity && tick &&
                           (wdReg == WCW'(WDOG_TICKS - 1));
    end
  endgenerate

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic         clk,
  input  logic         arstN,
  input  logic         supplyGood,
  input  logic         extActive,
  input  logic         stretchDone,
  input  logic         wdogExpired,
  output ctrlStrobes_t stb,
  output logic         rstActive
);

  supvState_e state;
  supvState_e stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_HOLD:    if (supplyGood) stateNxt = ST_STRETCH;
      ST_STRETCH: begin
        if (!supplyGood)      stateNxt = ST_HOLD;
        else if (stretchDone) stateNxt = ST_RUN;
      end
      ST_RUN: begin
        if (!supplyGood)                   stateNxt = ST_HOLD;
        else if (extActive || wdogExpired) stateNxt = ST_STRETCH;
      end
      default:                             stateNxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= ST_HOLD;
    else        state <= stateNxt;
  end

  assign stb.runStretch = (state == ST_STRETCH);
  assign stb.runWdog    = (state == ST_RUN);
  assign rstActive      = (state != ST_RUN);

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import supv_pkg::*;
#(
  parameter int GLITCH_CYCLES = 2,
  parameter int TICK_DIV      = 10000,
  parameter int STRETCH_TICKS = 200,
  parameter int WDOG_TICKS    = 1600,
  parameter int WDOG_SRC      = WDSRC_KICK
) (
  input  logic clk,
  input  logic arstN,
  input  logic supplyOk,
  input  logic extRstN,
  input  logic wdKick,
  input  logic chipSel,
  output logic rstOut,
  output logic rstOutN,
  output logic rstDriveEn
);

  localparam int WCW = $clog2(WDOG_TICKS + 1);

  ctrlStrobes_t   stb;
  logic           supplyGood;
  logic           extActive;
  logic           stretchDone;
  logic           wdogExpired;
  logic [WCW-1:0] wdCnt;
  logic           rstActive;

  supv_datapath #(
    .GLITCH_CYCLES(GLITCH_CYCLES),
    .TICK_DIV     (TICK_DIV),
    .STRETCH_TICKS(STRETCH_TICKS),
    .WDOG_TICKS   (WDOG_TICKS),
    .WDOG_SRC     (WDOG_SRC),
    .WCW          (WCW)
  ) dp_i (
    .clk        (clk),
    .arstN      (arstN),
    .supplyOk   (supplyOk),
    .extRstN    (extRstN),
    .wdKick     (wdKick),
    .chipSel    (chipSel),
    .stb        (stb),
    .supplyGood (supplyGood),
    .extActive  (extActive),
    .stretchDone(stretchDone),
    .wdogExpired(wdogExpired),
    .wdCnt      (wdCnt)
  );

  supv_ctrl ctrl_i (
    .clk        (clk),
    .arstN      (arstN),
    .supplyGood (supplyGood),
    .extActive  (extActive),
    .stretchDone(stretchDone),
    .wdogExpired(wdogExpired),
    .stb        (stb),
    .rstActive  (rstActive)
  );

  assign rstOut     = rstActive;
  assign rstOutN    = ~rstActive;
  assign rstDriveEn = rstActive;

endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
  parameter int WCW        = 11,
  parameter int WDOG_TICKS = 1600
) (
  input logic           clk,
  input logic           arstN,
  input logic           rstOut,
  input logic           supplyGood,
  input logic           stretchDone,
  input logic           wdogExpired,
  input logic [WCW-1:0] wdCnt
);

  // R1: a low filtered supply forces reset on the next cycle
  p_hold_low_r1: assert property (@(posedge clk) disable iff (!arstN)
    !supplyGood |=> rstOut);

  // R1: release only happens with the supply good
  p_release_supply_r1: assert property (@(posedge clk) disable iff (!arstN)
    $fell(rstOut) |-> $past(supplyGood));

  // R2: release only at the end of a completed stretch
  p_release_stretch_r2: assert property (@(posedge clk) disable iff (!arstN)
    $fell(rstOut) |-> $past(stretchDone));

  // R6: watchdog count is zero after any cycle spent in reset
  p_wdog_cleared_r6: assert property (@(posedge clk) disable iff (!arstN)
    rstOut |=> (wdCnt == '0));

  // R5: watchdog count never passes its terminal value
  p_wdog_range_r5: assert property (@(posedge clk) disable iff (!arstN)
    wdCnt <= WCW'(WDOG_TICKS - 1));

  // R9: expiry leads to reset
  p_expire_resets_r9: assert property (@(posedge clk) disable iff (!arstN)
    wdogExpired |=> rstOut);

endmodule

bind supv_reset_ctrl supv_reset_chk #(.WCW(WCW), .WDOG_TICKS(WDOG_TICKS)) chk_i (
  .clk        (clk),
  .arstN      (arstN),
  .rstOut     (rstOut),
  .supplyGood (supplyGood),
  .stretchDone(stretchDone),
  .wdogExpired(wdogExpired),
  .wdCnt      (wdCnt)
);

// File: tb/supv_reset_ctrl_tb_top.sv
module supv_reset_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int G = 4;
  localparam int S = 40;
  localparam int W = 60;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic supplyOk = 1'b0;
  logic extRstN = 1'b1;
  logic wdKick = 1'b0;
  logic chipSel = 1'b0;

  logic rst0, rstN0, drv0;
  logic rst1, rstN1, drv1;
  logic rst2, rstN2, drv2;

  int total = 0;
  int bad = 0;
  logic csSawReset = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supv_reset_ctrl #(.GLITCH_CYCLES(G), .TICK_DIV(1), .STRETCH_TICKS(S),
                    .WDOG_TICKS(W), .WDOG_SRC(1)) dut_i (
    .clk(clk), .arstN(arstN), .supplyOk(supplyOk), .extRstN(extRstN),
    .wdKick(wdKick), .chipSel(chipSel),
    .rstOut(rst0), .rstOutN(rstN0), .rstDriveEn(drv0));

  supv_reset_ctrl #(.GLITCH_CYCLES(G), .TICK_DIV(1), .STRETCH_TICKS(S),
                    .WDOG_TICKS(W), .WDOG_SRC(2)) dutCs_i (
    .clk(clk), .arstN(arstN), .supplyOk(supplyOk), .extRstN(extRstN),
    .wdKick(wdKick), .chipSel(chipSel),
    .rstOut(rst1), .rstOutN(rstN1), .rstDriveEn(drv1));

  supv_reset_ctrl #(.GLITCH_CYCLES(G), .TICK_DIV(1), .STRETCH_TICKS(S),
                    .WDOG_TICKS(W), .WDOG_SRC(0)) dutOff_i (
    .clk(clk), .arstN(arstN), .supplyOk(supplyOk), .extRstN(extRstN),
    .wdKick(wdKick), .chipSel(chipSel),
    .rstOut(rst2), .rstOutN(rstN2), .rstDriveEn(drv2));

  // expected latencies from the requirements
  function automatic int expAssertLat();  return G + 3;     endfunction
  function automatic int expReleaseLat(); return G + S + 3; endfunction
  function automatic int expExtLat();     return 3;         endfunction

  function automatic logic getRst(input int which);
    case (which)
      0:       return rst0;
      1:       return rst1;
      default: return rst2;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rst1) csSawReset = 1'b1;
    end
  endtask

  task automatic countUntil(input int which, input logic lvl, input int limit,
                            output int n);
    n = 0;
    while (getRst(which) !== lvl && n < limit) begin
      cyc(1);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int gap;
    int seedSink;
    seedSink = $urandom(32'd1729);

    // R7: reset state of outputs
    repeat (3) @(negedge clk);
    check("R7 rstOut in reset", int'(rst0), 1);
    check("R7 rstOutN in reset", int'(rstN0), 0);
    check("R7 drive in reset", int'(drv0), 1);
    arstN = 1'b1;

    // R1: supply low keeps reset
    cyc(20);
    check("R1 supply low holds reset", int'(rst0), 1);

    // R3: short high pulse on supply is ignored
    supplyOk = 1'b1;
    cyc(G - 1);
    supplyOk = 1'b0;
    cyc(S + 20);
    check("R3 short high pulse ignored", int'(rst0), 1);

    // R2: power-up release timing
    supplyOk = 1'b1;
    countUntil(0, 1'b0, 500, n);
    check("R2 release latency", n, expReleaseLat());
    check("R7 rstOutN released", int'(rstN0), 1);
    check("R7 drive released", int'(drv0), 0);
    check("R8 off copy released", int'(rst2), 0);

    // R5: no activity, expiry after W
    countUntil(0, 1'b1, 500, n);
    check("R5 expiry with no activity", n, W);
    check("R8 disabled watchdog never expires", int'(rst2), 0);
    check("R8 cs copy expires without cs edges", int'(rst1), 1);

    // R9: expiry stretch, R6: full window after release
    countUntil(0, 1'b0, 500, n);
    check("R9 stretch after expiry", n, S);
    countUntil(0, 1'b1, 500, n);
    check("R6 full window after release", n, W);
    countUntil(0, 1'b0, 500, n);
    check("R9 second stretch", n, S);

    // R5 random kicks within the window
    csSawReset = 1'b0;
    for (int k = 0; k < 30; k++) begin
      wdKick = ~wdKick;
      gap = 1 + int'($urandom % W);
      cyc(gap);
      check("R5 kicked watchdog stays quiet", int'(rst0), 0);
    end
    check("R8 kick ignored by cs copy", int'(csSawReset), 1);

    // R8: chip-select edges keep the cs copy alive
    countUntil(1, 1'b0, 500, n);
    for (int k = 0; k < 20; k++) begin
      chipSel = ~chipSel;
      gap = 1 + int'($urandom % W);
      cyc(gap);
      check("R8 cs edges keep watchdog quiet", int'(rst1), 0);
    end

    // R4: external reset while running
    countUntil(0, 1'b0, 500, n);
    extRstN = 1'b0;
    countUntil(0, 1'b1, 50, n);
    check("R4 external reset latency", n, expExtLat());
    check("R4 off copy reset by pin", int'(rst2), 1);
    cyc(10);
    extRstN = 1'b1;
    countUntil(0, 1'b0, 500, n);
    check("R4 pin ignored while driving", n, S - 10);
    check("R4 off copy released", int'(rst2), 0);

    // R1: supply fall latency
    supplyOk = 1'b0;
    countUntil(2, 1'b1, 100, n);
    check("R1 assert latency on fall", n, expAssertLat());
    cyc(2);
    check("R1 all copies in reset", int'(rst0 & rst1 & rst2), 1);

    // R2 again, then R3 low glitches
    supplyOk = 1'b1;
    countUntil(2, 1'b0, 500, n);
    check("R2 release latency second", n, expReleaseLat());
    supplyOk = 1'b0;
    cyc(G - 1);
    supplyOk = 1'b1;
    cyc(S + 20);
    check("R3 short low pulse ignored", int'(rst2), 0);
    supplyOk = 1'b0;
    cyc(G);
    supplyOk = 1'b1;
    countUntil(2, 1'b1, 50, n);
    check("R3 pulse of filter length accepted", n, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule